// File: doc/BRIEF.md
# Multi-function Data Unit

This block is a small sequential engine built around one working register whose active width can be set from 1 to 8 bits. It sits beside a set of lookup-table cells in a pin-side logic fabric. It takes three single-bit triggers, two 8-bit data operands, a 3-bit width field and a 4-bit opcode. It returns one result bit, which can be routed back into the lookup cells. The working register is also visible on an output port. The selection of trigger and data sources takes place outside the block, so every input arrives already resolved.

The first trigger is a synchronous load that copies the first operand into the register. The second trigger enables one count or shift step per clock. The third trigger has two uses: it picks the count direction in the up/down modes, and it is the serial bit that enters at the top of the active width in the shift modes.

The opcode picks one of seven behaviour modes through a decode stage:

- **idle:** no change to the register.
- **count:** saturating or wrapping, in a fixed or an external direction.
- **rotate:** right rotation inside the active width.
- **shift:** right shift with a serial bit entering at the top.
- **bit test:** an AND/OR check of the two operands.
- **majority:** a majority vote over the three low register bits, with a shift.
- **equality:** a compare against the second operand, with a shift.

Each mode has its own next-register transition and its own result equation.

Top module: `seq_data_unit`

## Requirements
- R1: After reset the working register reads 0. With opcode 0 and no triggers, the result is 0.
- R2: When `trig_load` is 1, the next clock edge loads the active-width bits of `opnd_a` into the register. This takes priority over any step requested in the same cycle.
- R3: Only the low (`width_sel`+1) bits take part in the operation. Both operands and the register are masked to that width. The bits above it read as 0 on `work_q`, and arithmetic wraps modulo the active width.
- R4: Opcode 1 (increment) adds 1 on each step until the register equals the masked `opnd_b`, then holds there. The result is 1 while the register equals the masked `opnd_b`.
- R5: Opcode 2 (decrement) subtracts 1 on each step until the register is 0, then holds there. The result is 1 while the register is 0.
- R6: Opcode 3 (increment, wrapping) reloads the masked `opnd_a` on a step taken at the masked `opnd_b`. Opcode 4 (decrement, wrapping) reloads the masked `opnd_a` on a step taken at 0. The result is 1 at the respective limit.
- R7: Opcodes 5 (saturating) and 6 (wrapping) count down when `trig_aux` is 1 and count up when it is 0. The limit and the result follow the chosen direction.
- R8: Opcode 7 rotates the active width right by one on each step: bit 0 moves to bit `width_sel`. The result is bit 0 of the register.
- R9: Opcode 8 shifts the active width right on each step, with `trig_aux` entering at bit `width_sel`. The result is bit 0 of the register.
- R10: Opcode 9 outputs 1 when the masked `opnd_a` AND the masked `opnd_b` is non-zero, and 0 otherwise. Opcode 9 never changes the register.
- R11: Opcode 10 shifts like opcode 8. Its result is 1 when at least two of register bits 2..0 are 1.
- R12: Opcode 11 shifts like opcode 8. Its result is 1 when the register equals the masked `opnd_b`.
- R13: With `trig_step` low and no load, the register holds. Opcodes 0 and 12 to 15 never change the register, and their result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_load | input | 1 | Synchronous load of operand A |
| trig_step | input | 1 | Count/shift step enable |
| trig_aux | input | 1 | Direction (1 = down) in opcodes 5/6; serial bit in the shift modes |
| opnd_a | input | 8 | First data operand (load / reload value) |
| opnd_b | input | 8 | Second data operand (limit / compare value) |
| width_sel | input | 3 | Active width minus one |
| op_code | input | 4 | Operation select |
| work_q | output | 8 | Working register, masked to the active width |
| result | output | 1 | Single-bit result |

## Verification
- **Register effect:** a load or a step changes `work_q` at the first rising edge after the inputs are applied, one register stage in all.
- **Result timing:** `result` is a combinational function of that register and of the current operands, so it is valid in the same cycle as `work_q`.
- **Bit test:** opcode 9 involves no register at all, so its result follows the operands with zero delay.
- **How the checks keep to this:** the driver applies each stimulus at a falling edge and queues the expected register value and result. The monitor compares both 2 ns after the next rising edge, while the same inputs are still held.

// File: rtl/sdu_pkg.sv
package sdu_pkg;

    typedef enum logic [3:0] {
        OPC_NOP       = 4'd0,
        OPC_INC       = 4'd1,
        OPC_DEC       = 4'd2,
        OPC_INC_WRAP  = 4'd3,
        OPC_DEC_WRAP  = 4'd4,
        OPC_UPDN      = 4'd5,
        OPC_UPDN_WRAP = 4'd6,
        OPC_ROTR      = 4'd7,
        OPC_SHIFT_IN  = 4'd8,
        OPC_ANDOR     = 4'd9,
        OPC_MAJ3      = 4'd10,
        OPC_EQUAL     = 4'd11
    } sdu_opc_e;

    typedef enum logic [2:0] {
        MODE_IDLE,
        MODE_COUNT,
        MODE_ROTATE,
        MODE_SHIFT,
        MODE_BITTEST,
        MODE_MAJORITY,
        MODE_EQUAL
    } sdu_mode_e;

    typedef enum logic [1:0] {
        DIR_UP,
        DIR_DOWN,
        DIR_EXTERNAL
    } sdu_dir_e;

endpackage

// File: rtl/sdu_mode_decode.sv
module sdu_mode_decode
    import sdu_pkg::*;
(
    input  logic [3:0] op_code,
    output sdu_mode_e  mode,
    output sdu_dir_e   dir_kind,
    output logic       wraps
);

    always_comb begin
        mode     = MODE_IDLE;
        dir_kind = DIR_UP;
        wraps    = 1'b0;
        unique case (op_code)
            OPC_INC: begin
                mode = MODE_COUNT;
            end
            OPC_DEC: begin
                mode     = MODE_COUNT;
                dir_kind = DIR_DOWN;
            end
            OPC_INC_WRAP: begin
                mode  = MODE_COUNT;
                wraps = 1'b1;
            end
            OPC_DEC_WRAP: begin
                mode     = MODE_COUNT;
                dir_kind = DIR_DOWN;
                wraps    = 1'b1;
            end
            OPC_UPDN: begin
                mode     = MODE_COUNT;
                dir_kind = DIR_EXTERNAL;
            end
            OPC_UPDN_WRAP: begin
                mode     = MODE_COUNT;
                dir_kind = DIR_EXTERNAL;
                wraps    = 1'b1;
            end
            OPC_ROTR:     mode = MODE_ROTATE;
            OPC_SHIFT_IN: mode = MODE_SHIFT;
            OPC_ANDOR:    mode = MODE_BITTEST;
            OPC_MAJ3:     mode = MODE_MAJORITY;
            OPC_EQUAL:    mode = MODE_EQUAL;
            default:      mode = MODE_IDLE;
        endcase
    end

endmodule

// File: rtl/sdu_step_logic.sv
module sdu_step_logic
    import sdu_pkg::*;
#(
    parameter int DW = 8,
    localparam int SW = $clog2(DW)
) (
    input  sdu_mode_e       mode,
    input  logic            wraps,
    input  logic            count_down,
    input  logic            serial_in,
    input  logic [SW-1:0]   width_sel,
    input  logic [DW-1:0]   act_mask,
    input  logic [DW-1:0]   cur,
    input  logic [DW-1:0]   lo_a,
    input  logic [DW-1:0]   lo_b,
    output logic [DW-1:0]   nxt,
    output logic            at_limit
);

    logic [DW-1:0] top_bit_rot;
    logic [DW-1:0] top_bit_ser;
    logic [DW-1:0] raw_next;

    assign top_bit_rot = {{(DW-1){1'b0}}, cur[0]} << width_sel;
    assign top_bit_ser = {{(DW-1){1'b0}}, serial_in} << width_sel;

    // Terminal value depends on direction: zero going down, operand B going up.
    assign at_limit = count_down ? (cur == '0) : (cur == lo_b);

    always_comb begin
        raw_next = cur;
        unique case (mode)
            MODE_COUNT: begin
                if (at_limit) begin
                    raw_next = wraps ? lo_a : cur;
                end else if (count_down) begin
                    raw_next = cur - DW'(1);
                end else begin
                    raw_next = cur + DW'(1);
                end
            end
            MODE_ROTATE: raw_next = (cur >> 1) | top_bit_rot;
            MODE_SHIFT, MODE_MAJORITY, MODE_EQUAL:
                raw_next = (cur >> 1) | top_bit_ser;
            MODE_IDLE, MODE_BITTEST: raw_next = cur;
            default: raw_next = cur;
        endcase
    end

    assign nxt = raw_next & act_mask;

endmodule

// File: rtl/sdu_result_mux.sv
module sdu_result_mux
    import sdu_pkg::*;
#(
    parameter int DW = 8
) (
    input  sdu_mode_e     mode,
    input  logic          at_limit,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] lo_a,
    input  logic [DW-1:0] lo_b,
    output logic          bit_out
);

    logic maj3;

    assign maj3 = (cur[0] & cur[1]) | (cur[1] & cur[2]) | (cur[0] & cur[2]);

    always_comb begin
        bit_out = 1'b0;
        unique case (mode)
            MODE_COUNT:    bit_out = at_limit;
            MODE_ROTATE,
            MODE_SHIFT:    bit_out = cur[0];
            MODE_BITTEST:  bit_out = |(lo_a & lo_b);
            MODE_MAJORITY: bit_out = maj3;
            MODE_EQUAL:    bit_out = (cur == lo_b);
            MODE_IDLE:     bit_out = 1'b0;
            default:       bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_data_unit.sv
module seq_data_unit
    import sdu_pkg::*;
#(
    parameter int DW = 8,
    localparam int SW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_load,
    input  logic          trig_step,
    input  logic          trig_aux,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [SW-1:0] width_sel,
    input  logic [3:0]    op_code,
    output logic [DW-1:0] work_q,
    output logic          result
);

    logic [DW-1:0] act_mask;
    logic [DW-1:0] work_r;
    logic [DW-1:0] cur;
    logic [DW-1:0] lo_a;
    logic [DW-1:0] lo_b;
    logic [DW-1:0] nxt;
    logic          at_limit;
    logic          count_down;
    logic          bit_out;
    sdu_mode_e     mode;
    sdu_dir_e      dir_kind;
    logic          wraps;

    // Thermometer mask: bit i is active when i <= width_sel.
    for (genvar gi = 0; gi < DW; gi++) begin : g_mask
        assign act_mask[gi] = (width_sel >= SW'(gi));
    end

    assign cur  = work_r & act_mask;
    assign lo_a = opnd_a & act_mask;
    assign lo_b = opnd_b & act_mask;

    sdu_mode_decode u_dec (
        .op_code  (op_code),
        .mode     (mode),
        .dir_kind (dir_kind),
        .wraps    (wraps)
    );

    always_comb begin
        unique case (dir_kind)
            DIR_DOWN:     count_down = 1'b1;
            DIR_EXTERNAL: count_down = trig_aux;
            default:      count_down = 1'b0;
        endcase
    end

    sdu_step_logic #(.DW(DW)) u_step (
        .mode       (mode),
        .wraps      (wraps),
        .count_down (count_down),
        .serial_in  (trig_aux),
        .width_sel  (width_sel),
        .act_mask   (act_mask),
        .cur        (cur),
        .lo_a       (lo_a),
        .lo_b       (lo_b),
        .nxt        (nxt),
        .at_limit   (at_limit)
    );

    sdu_result_mux #(.DW(DW)) u_res (
        .mode     (mode),
        .at_limit (at_limit),
        .cur      (cur),
        .lo_a     (lo_a),
        .lo_b     (lo_b),
        .bit_out  (bit_out)
    );

    // State register: load wins over step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_r <= '0;
        end else if (trig_load) begin
            work_r <= lo_a;
        end else if (trig_step) begin
            work_r <= nxt;
        end
    end

    // Output process.
    always_comb begin
        work_q = cur;
        result = bit_out;
    end

endmodule

// File: rtl/sdu_checks.sv
module sdu_checks #(
    parameter int DW = 8,
    localparam int SW = $clog2(DW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_load,
    input logic          trig_step,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic [SW-1:0] width_sel,
    input logic [3:0]    op_code,
    input logic [DW-1:0] work_q,
    input logic          result
);

    function automatic logic [DW-1:0] fmask(input logic [SW-1:0] w);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = (i <= int'(w));
        return m;
    endfunction

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_load |=> ((width_sel != $past(width_sel)) ||
                       (work_q == ($past(opnd_a) & fmask(width_sel)))));

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_load && !trig_step) |=>
            ((width_sel != $past(width_sel)) || (work_q == $past(work_q))));

    assert_sat_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1 && trig_step && !trig_load &&
         work_q == (opnd_b & fmask(width_sel))) |=>
            ((width_sel != $past(width_sel)) || (work_q == $past(work_q))));

    assert_bittest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd9) |-> (result == (|(opnd_a & opnd_b & fmask(width_sel)))));

    assert_majority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd10) |-> (result == ($countones(work_q[2:0]) >= 2)));

    assert_equal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd11) |-> (result == (work_q == (opnd_b & fmask(width_sel)))));

endmodule

bind seq_data_unit sdu_checks #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_load (trig_load),
    .trig_step (trig_step),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .width_sel (width_sel),
    .op_code   (op_code),
    .work_q    (work_q),
    .result    (result)
);

// File: tb/sim_seq_data_unit.sv
`timescale 1ns/1ps
module sim_seq_data_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_load = 1'b0;
    logic       trig_step = 1'b0;
    logic       trig_aux = 1'b0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [2:0] width_sel = 3'd7;
    logic [3:0] op_code = '0;
    logic [7:0] work_q;
    logic       result;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] exp_work;
        logic       exp_res;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    seq_data_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_load (trig_load),
        .trig_step (trig_step),
        .trig_aux  (trig_aux),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .width_sel (width_sel),
        .op_code   (op_code),
        .work_q    (work_q),
        .result    (result)
    );

    task automatic apply(input logic [3:0] op, input logic [2:0] sz,
                         input logic [7:0] a, input logic [7:0] b,
                         input bit ld, input bit st, input bit ax,
                         input logic [7:0] ew, input bit er, input string tag);
        exp_t it;
        @(negedge clk);
        op_code = op; width_sel = sz; opnd_a = a; opnd_b = b;
        trig_load = ld; trig_step = st; trig_aux = ax;
        it.exp_work = ew; it.exp_res = er; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares one queued item 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            total++;
            if (work_q !== it.exp_work || result !== it.exp_res) begin
                bad++;
                $display("FAIL %s: work_q=%h result=%b expected work_q=%h result=%b",
                         it.tag, work_q, result, it.exp_work, it.exp_res);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        //     op    sz   a      b      ld st ax  work   res tag
        apply(4'd0, 3'd7, 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R1 reset");
        // R2 load wins over step, R4 saturating up-count
        apply(4'd1, 3'd7, 8'h05, 8'h07, 1, 1, 0, 8'h05, 0, "R2 load");
        apply(4'd1, 3'd7, 8'h05, 8'h07, 0, 1, 0, 8'h06, 0, "R4 inc");
        apply(4'd1, 3'd7, 8'h05, 8'h07, 0, 1, 0, 8'h07, 1, "R4 reach");
        apply(4'd1, 3'd7, 8'h05, 8'h07, 0, 1, 0, 8'h07, 1, "R4 saturate");
        apply(4'd1, 3'd7, 8'h05, 8'h07, 0, 0, 0, 8'h07, 1, "R13 no step");
        apply(4'd12, 3'd7, 8'h05, 8'h07, 0, 1, 0, 8'h07, 0, "R13 unused opcode");
        // R5 saturating down-count
        apply(4'd2, 3'd7, 8'h02, 8'h00, 1, 0, 0, 8'h02, 0, "R5 load");
        apply(4'd2, 3'd7, 8'h02, 8'h00, 0, 1, 0, 8'h01, 0, "R5 dec");
        apply(4'd2, 3'd7, 8'h02, 8'h00, 0, 1, 0, 8'h00, 1, "R5 zero");
        apply(4'd2, 3'd7, 8'h02, 8'h00, 0, 1, 0, 8'h00, 1, "R5 saturate");
        // R6 wrapping counters
        apply(4'd3, 3'd7, 8'h03, 8'h05, 1, 0, 0, 8'h03, 0, "R6 up load");
        apply(4'd3, 3'd7, 8'h03, 8'h05, 0, 1, 0, 8'h04, 0, "R6 up step");
        apply(4'd3, 3'd7, 8'h03, 8'h05, 0, 1, 0, 8'h05, 1, "R6 up limit");
        apply(4'd3, 3'd7, 8'h03, 8'h05, 0, 1, 0, 8'h03, 0, "R6 up reload");
        apply(4'd4, 3'd7, 8'h02, 8'h00, 1, 0, 0, 8'h02, 0, "R6 dn load");
        apply(4'd4, 3'd7, 8'h02, 8'h00, 0, 1, 0, 8'h01, 0, "R6 dn step");
        apply(4'd4, 3'd7, 8'h02, 8'h00, 0, 1, 0, 8'h00, 1, "R6 dn limit");
        apply(4'd4, 3'd7, 8'h02, 8'h00, 0, 1, 0, 8'h02, 0, "R6 dn reload");
        // R7 external direction
        apply(4'd5, 3'd7, 8'h04, 8'h09, 1, 0, 0, 8'h04, 0, "R7 load");
        apply(4'd5, 3'd7, 8'h04, 8'h09, 0, 1, 0, 8'h05, 0, "R7 up");
        apply(4'd5, 3'd7, 8'h04, 8'h09, 0, 1, 1, 8'h04, 0, "R7 down");
        apply(4'd6, 3'd7, 8'h01, 8'h02, 1, 0, 1, 8'h01, 0, "R7 wrap load");
        apply(4'd6, 3'd7, 8'h01, 8'h02, 0, 1, 1, 8'h00, 1, "R7 wrap down zero");
        apply(4'd6, 3'd7, 8'h01, 8'h02, 0, 1, 1, 8'h01, 0, "R7 wrap down reload");
        apply(4'd6, 3'd7, 8'h01, 8'h02, 0, 1, 0, 8'h02, 1, "R7 wrap up limit");
        apply(4'd6, 3'd7, 8'h01, 8'h02, 0, 1, 0, 8'h01, 0, "R7 wrap up reload");
        // R3 width masking
        apply(4'd3, 3'd2, 8'h0E, 8'hFF, 1, 0, 0, 8'h06, 0, "R3 masked load");
        apply(4'd3, 3'd2, 8'h0E, 8'hFF, 0, 1, 0, 8'h07, 1, "R3 masked limit");
        apply(4'd3, 3'd2, 8'h0E, 8'hFF, 0, 1, 0, 8'h06, 0, "R3 masked reload");
        apply(4'd0, 3'd0, 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, "R3 upper bits zero");
        // R8 rotate in 4 bits
        apply(4'd7, 3'd3, 8'h03, 8'h00, 1, 1, 0, 8'h03, 1, "R8 load");
        apply(4'd7, 3'd3, 8'h03, 8'h00, 0, 1, 0, 8'h09, 1, "R8 rot1");
        apply(4'd7, 3'd3, 8'h03, 8'h00, 0, 1, 0, 8'h0C, 0, "R8 rot2");
        apply(4'd7, 3'd3, 8'h03, 8'h00, 0, 1, 0, 8'h06, 0, "R8 rot3");
        // R9 serial shift in 4 bits
        apply(4'd8, 3'd3, 8'h00, 8'h00, 1, 0, 0, 8'h00, 0, "R9 load");
        apply(4'd8, 3'd3, 8'h00, 8'h00, 0, 1, 1, 8'h08, 0, "R9 shift1");
        apply(4'd8, 3'd3, 8'h00, 8'h00, 0, 1, 1, 8'h0C, 0, "R9 shift1b");
        apply(4'd8, 3'd3, 8'h00, 8'h00, 0, 1, 0, 8'h06, 0, "R9 shift0");
        apply(4'd8, 3'd3, 8'h00, 8'h00, 0, 1, 1, 8'h0B, 1, "R9 shift lsb");
        // R10 bit test
        apply(4'd9, 3'd7, 8'h30, 8'h10, 0, 0, 0, 8'h0B, 1, "R10 overlap");
        apply(4'd9, 3'd7, 8'h30, 8'h0F, 0, 0, 0, 8'h0B, 0, "R10 disjoint");
        apply(4'd9, 3'd3, 8'h30, 8'h10, 0, 0, 0, 8'h0B, 0, "R10 masked");
        apply(4'd9, 3'd7, 8'h01, 8'h01, 0, 1, 0, 8'h0B, 1, "R10 step no change");
        // R11 majority with shift
        apply(4'd10, 3'd7, 8'h05, 8'h00, 1, 0, 0, 8'h05, 1, "R11 two ones");
        apply(4'd10, 3'd7, 8'h05, 8'h00, 0, 1, 0, 8'h02, 0, "R11 one one");
        apply(4'd10, 3'd7, 8'h06, 8'h00, 1, 0, 0, 8'h06, 1, "R11 load six");
        apply(4'd10, 3'd7, 8'h06, 8'h00, 0, 1, 1, 8'h83, 1, "R11 shift in");
        // R12 equality with shift
        apply(4'd11, 3'd7, 8'h08, 8'h04, 1, 0, 0, 8'h08, 0, "R12 unequal");
        apply(4'd11, 3'd7, 8'h08, 8'h04, 0, 1, 0, 8'h04, 1, "R12 equal");
        apply(4'd11, 3'd7, 8'h08, 8'h04, 0, 1, 0, 8'h02, 0, "R12 shifted past");
        apply(4'd11, 3'd3, 8'h08, 8'h12, 0, 0, 0, 8'h02, 1, "R12 masked compare");
        @(negedge clk);
        trig_load = 0; trig_step = 0;
        repeat (3) @(posedge clk);
        #3;
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule